// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt inputs into one request line for a processor. Each input is latched into a status bit. An input is captured on its rising edge or held as a level, and a kind mask fixed at build time chooses which. Software controls the block through eight word registers on a simple 32-bit register bus:

- It can enable inputs directly, or set and clear enable bits without a read-modify-write.
- It acknowledges serviced inputs by writing ones.
- It reads a vector register that names the lowest-numbered input that is both latched and enabled.

The request line is registered. It rises only after software has turned on both master bits.

The bus accepts every access in the cycle it is presented, so there is no back-pressure and no ready signal. A write takes effect at the clock edge where `bus_wr_en` is sampled high. A read returns its data on `bus_rdata` from the edge where `bus_rd_en` is sampled high, and holds that data until the next read. The registers sit at byte offsets that are multiples of 4:

| Offset | Register |
|---|---|
| 0x00 | status |
| 0x04 | pending |
| 0x08 | enable |
| 0x0C | acknowledge |
| 0x10 | set-enable |
| 0x14 | clear-enable |
| 0x18 | vector |
| 0x1C | master |

Top module: `vic_top`

## Requirements
- R1: After reset, status, enable, pending and master all read 0, the vector reads 0xFFFFFFFF and `irq_out` is 0.
- R2: An input whose `KIND_MASK` bit is 1 sets its status bit on a 0-to-1 transition only. The bit stays set after the input falls. After it is acknowledged, it stays clear while the input is held high.
- R3: An input whose `KIND_MASK` bit is 0 sets its status bit in every cycle the input is high. An acknowledge issued while the input is still high therefore leaves the bit set.
- R4: Writing to the acknowledge register (0x0C) clears each status bit where the written data has a 1. Zero bits leave status unchanged, and writing 0xFFFFFFFF clears every status bit.
- R5: A write to 0x08 loads the enable register. A write to 0x10 ORs the data into it. A write to 0x14 clears the enable bits where the data has a 1. Set and clear leave all other enable bits unchanged.
- R6: Pending (0x04) reads status AND enable. Writes to 0x04 change neither status nor enable.
- R7: The vector (0x18) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R8: The master register (0x1C) has bit 0 as the master-on bit and bit 1 as the hardware-request bit. Writing a 1 to either bit sets it, and the bit stays set until reset. `irq_out` is 1 in the cycle after one in which some bit is pending and both master bits are 1, and 0 otherwise.
- R9: Status, enable and pending bits at index `NUM_IN` and above always read 0. Kind-mask bits at those indices have no effect.
- R10: The acknowledge, set-enable and clear-enable registers read 0. Accesses whose address bits [1:0] are not 00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one access per cycle |
| bus_rd_en | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_IN | Interrupt inputs |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench holds an edge-kind input high through an acknowledge. A design that treated that input as a level would set the bit again and report it. It also acknowledges a level input that is still asserted, which catches a design where the clear wins over a fresh capture. Set-enable and clear-enable are checked for bits they must leave alone, so a plain overwrite shows up as lost enables. The master bits are raised one at a time across a reset, so a single-bit gate or a master bit that can be cleared by writing 0 raises the request when it must not.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  // word index taken from address bits [4:2]
  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_PENDING = 3'd1,
    SEL_ENABLE  = 3'd2,
    SEL_ACK     = 3'd3,
    SEL_SETEN   = 3'd4,
    SEL_CLREN   = 3'd5,
    SEL_VECTOR  = 3'd6,
    SEL_MASTER  = 3'd7
  } reg_sel_e;

  localparam int MST_ON_BIT = 0;
  localparam int MST_HW_BIT = 1;
  localparam int MST_W      = 2;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] ack_mask,
  output logic [NUM_IN-1:0] status
);
  logic [NUM_IN-1:0] hit;
  logic [NUM_IN-1:0] status_q;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    if (KIND_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[i];
      end
      assign hit[i] = irq_in[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = irq_in[i];
    end
  end

  // a fresh capture wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~ack_mask) | hit;
  end

  assign status = status_q;
endmodule

// File: rtl/vic_enable.sv
module vic_enable #(
  parameter int NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              set,
  input  logic              clr,
  input  logic [NUM_IN-1:0] data,
  output logic [NUM_IN-1:0] enable
);
  logic [NUM_IN-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= '0;
    else if (load) en_q <= data;
    else if (set)  en_q <= en_q | data;
    else if (clr)  en_q <= en_q & ~data;
  end

  assign enable = en_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NUM_IN = 32,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] pending,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  // scan from the top so the lowest index is the last one written
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_IN-1:0]   irq_in,
  output logic                irq_out
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  reg_sel_e          sel;
  logic              aligned;
  logic              wr_ok;
  logic [NUM_IN-1:0] wr_bits;
  logic [NUM_IN-1:0] ack_mask;
  logic [NUM_IN-1:0] status_q;
  logic [NUM_IN-1:0] enable_q;
  logic [NUM_IN-1:0] pending;
  logic              any_found;
  logic [IDX_W-1:0]  any_idx;
  logic [BUS_W-1:0]  vector;
  logic [MST_W-1:0]  master_q;
  logic              irq_q;
  logic [BUS_W-1:0]  rd_mux;
  logic [BUS_W-1:0]  rdata_q;

  assign sel      = reg_sel_e'(bus_addr[4:2]);
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_ok    = bus_wr_en & aligned;
  assign wr_bits  = bus_wdata[NUM_IN-1:0];
  assign ack_mask = (wr_ok && sel == SEL_ACK) ? wr_bits : '0;

  vic_capture #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .ack_mask (ack_mask),
    .status   (status_q)
  );

  vic_enable #(.NUM_IN(NUM_IN)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wr_ok && sel == SEL_ENABLE),
    .set    (wr_ok && sel == SEL_SETEN),
    .clr    (wr_ok && sel == SEL_CLREN),
    .data   (wr_bits),
    .enable (enable_q)
  );

  assign pending = status_q & enable_q;

  vic_prio #(.NUM_IN(NUM_IN)) u_prio (
    .pending (pending),
    .found   (any_found),
    .idx     (any_idx)
  );

  assign vector = any_found ? BUS_W'(any_idx) : '1;

  // master bits are sticky: writes can only raise them
  always_ff @(posedge clk) begin
    if (!rst_n)                        master_q <= '0;
    else if (wr_ok && sel == SEL_MASTER) master_q <= master_q | bus_wdata[MST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (|pending) & master_q[MST_ON_BIT] & master_q[MST_HW_BIT];
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS:  rd_mux = BUS_W'(status_q);
      SEL_PENDING: rd_mux = BUS_W'(pending);
      SEL_ENABLE:  rd_mux = BUS_W'(enable_q);
      SEL_VECTOR:  rd_mux = vector;
      SEL_MASTER:  rd_mux = BUS_W'(master_q);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (bus_rd_en && aligned) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_IN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [4:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NUM_IN-1:0] status,
  input logic [NUM_IN-1:0] enable,
  input logic [NUM_IN-1:0] pending,
  input logic [1:0]        master,
  input logic [31:0]       vector,
  input logic              irq_out
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  logic [NUM_IN-1:0] wbits;
  logic [NUM_IN-1:0] below;
  assign wbits = bus_wdata[NUM_IN-1:0];
  assign below = (NUM_IN'(1) << vector[IDX_W-1:0]) - NUM_IN'(1);

  a_r5_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 5'h10) |=> ((enable & $past(wbits)) == $past(wbits)));
  a_r5_set_others: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 5'h10) |=> ((enable & ~$past(wbits)) == ($past(enable) & ~$past(wbits))));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 5'h14) |=> ((enable & $past(wbits)) == '0));
  a_r6_pending_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~status) == '0) && ((pending & ~enable) == '0));
  a_r7_none: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vector == 32'hFFFF_FFFF));
  a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (vector != 32'hFFFF_FFFF) |-> (vector < NUM_IN && pending[vector[IDX_W-1:0]] && (pending & below) == '0));
  a_r8_master_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (master & $past(master)) == $past(master));
  a_r8_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (master != 2'b11) |=> !irq_out);
  a_r8_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pending) && master == 2'b11) |=> irq_out);
  a_r8_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> !irq_out);
endmodule

bind vic_top vic_checker #(.NUM_IN(NUM_IN)) u_vic_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .status    (status_q),
  .enable    (enable_q),
  .pending   (pending),
  .master    (master_q),
  .vector    (vector),
  .irq_out   (irq_out)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;
  localparam int NI = 8;
  // inputs 4 and 5 edge-kind; bits at 8 and above set but must not matter
  localparam logic [31:0] KM = 32'hFFFF_FF30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NI-1:0] irq_in = '0;
  logic        irq_out;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vic_top #(.NUM_IN(NI), .KIND_MASK(KM)) u_vic_top (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(input logic [NI-1:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic t_reset();
    apply_reset();
    check("R1 irq_out", 32'(irq_out), 0);
    expect_reg("R1 status", 5'h00, 0);
    expect_reg("R1 pending", 5'h04, 0);
    expect_reg("R1 enable", 5'h08, 0);
    expect_reg("R1 master", 5'h1C, 0);
    expect_reg("R1 vector", 5'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    apply_reset();
    @(negedge clk); irq_in[4] = 1'b1;
    expect_reg("R2 edge latched", 5'h00, 32'h10);
    irq_in[4] = 1'b0;
    expect_reg("R2 held after fall", 5'h00, 32'h10);
    irq_in[4] = 1'b1;
    wr(5'h0C, 32'h10);
    expect_reg("R2 no re-set while high", 5'h00, 0);
  endtask

  task automatic t_level();
    apply_reset();
    @(negedge clk); irq_in[1] = 1'b1;
    expect_reg("R3 level latched", 5'h00, 32'h02);
    wr(5'h0C, 32'h02);
    expect_reg("R3 re-set after ack", 5'h00, 32'h02);
    irq_in[1] = 1'b0;
    wr(5'h0C, 32'h02);
    expect_reg("R3 cleared once low", 5'h00, 0);
  endtask

  task automatic t_ack();
    apply_reset();
    pulse(8'h0D);
    expect_reg("R4 captured", 5'h00, 32'h0D);
    wr(5'h0C, 32'h0);
    expect_reg("R4 zero ack no effect", 5'h00, 32'h0D);
    wr(5'h0C, 32'h04);
    expect_reg("R4 single ack", 5'h00, 32'h09);
    wr(5'h0C, 32'hFFFF_FFFF);
    expect_reg("R4 ack all", 5'h00, 0);
  endtask

  task automatic t_enable();
    apply_reset();
    wr(5'h08, 32'h05);
    expect_reg("R5 load", 5'h08, 32'h05);
    wr(5'h10, 32'h0A);
    expect_reg("R5 set-enable", 5'h08, 32'h0F);
    wr(5'h14, 32'h03);
    expect_reg("R5 clear-enable", 5'h08, 32'h0C);
    wr(5'h08, 32'hFFFF_FFFF);
    expect_reg("R9 enable upper bits", 5'h08, 32'hFF);
  endtask

  task automatic t_pending();
    apply_reset();
    pulse(8'h05);
    wr(5'h08, 32'h06);
    expect_reg("R6 pending and", 5'h04, 32'h04);
    wr(5'h04, 32'hFF);
    expect_reg("R6 pending write ignored", 5'h04, 32'h04);
    expect_reg("R6 enable untouched", 5'h08, 32'h06);
    expect_reg("R6 status untouched", 5'h00, 32'h05);
  endtask

  task automatic t_vector();
    apply_reset();
    pulse(8'h48);
    expect_reg("R7 none enabled", 5'h18, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFF);
    expect_reg("R7 lowest", 5'h18, 32'd3);
    wr(5'h14, 32'h08);
    expect_reg("R7 next", 5'h18, 32'd6);
    wr(5'h0C, 32'h40);
    expect_reg("R7 empty", 5'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_master();
    apply_reset();
    pulse(8'h04);
    wr(5'h08, 32'h04);
    wr(5'h1C, 32'h1);
    @(negedge clk);
    check("R8 master-on alone", 32'(irq_out), 0);
    wr(5'h1C, 32'h2);
    check("R8 registered delay", 32'(irq_out), 0);
    @(negedge clk);
    check("R8 both bits", 32'(irq_out), 1);
    wr(5'h1C, 32'h0);
    expect_reg("R8 master sticky", 5'h1C, 32'h3);
    check("R8 stays on", 32'(irq_out), 1);
    wr(5'h0C, 32'h04);
    @(negedge clk);
    check("R8 drops after ack", 32'(irq_out), 0);
    apply_reset();
    pulse(8'h04);
    wr(5'h08, 32'h04);
    wr(5'h1C, 32'h2);
    repeat (2) @(negedge clk);
    check("R8 hw bit alone", 32'(irq_out), 0);
  endtask

  task automatic t_misc();
    apply_reset();
    wr(5'h10, 32'h0F);
    expect_reg("R10 ack reads 0", 5'h0C, 0);
    expect_reg("R10 set-enable reads 0", 5'h10, 0);
    expect_reg("R10 clear-enable reads 0", 5'h14, 0);
    wr(5'h09, 32'hF0);
    expect_reg("R10 misaligned write ignored", 5'h08, 32'h0F);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_ack();
    t_enable();
    t_pending();
    t_vector();
    t_master();
    t_misc();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule